// File: doc/BRIEF.md
# Atomic Memory Operation Unit

This unit carries out the memory accesses of one hardware thread against a single-port synchronous word memory. It handles plain loads and stores, a reserve/conditional-store pair for lock-free retry loops, and indivisible read-modify-write updates: add, swap, AND, OR, signed minimum and signed maximum. Once a request is accepted, the unit owns the memory port until its result is returned. Between the read and the write of an update, no other access can reach the port.

The unit holds a single reservation, made of a valid flag and a word address. A reserving load sets it. A conditional store consumes it. It is dropped when the snoop input reports another agent writing the reserved word, or when this unit itself writes that word. Every request is answered with one 32-bit response word. That word is the prior memory contents for loads and updates, and a status code for stores.

Top module: `amo_unit`

## Requirements
- R1: After reset, reqReady is 1, rspValid is 0, memEn is 0 and no reservation exists, so a conditional store issued first fails.
- R2: A request is taken on a rising edge with reqValid and reqReady both high. reqReady stays low from that edge until the response cycle has ended. rspValid is a single-cycle pulse in the third cycle after the accepting edge. reqReady is high again in the following cycle.
- R3: Operation codes on reqOp are 0 load, 1 store, 2 reserving load, 3 conditional store, 4 add, 5 swap, 6 AND, 7 OR, 8 signed min and 9 signed max. A load returns the addressed word. A store writes reqData there and returns 0.
- R4: A reserving load returns the addressed word and records a valid reservation for that address.
- R5: A conditional store to the address of a valid reservation writes reqData and returns 0.
- R6: A conditional store without a valid reservation for its own address performs no memory write and returns 1.
- R7: Every conditional store clears the reservation, whether it succeeds or fails.
- R8: A snoop (snoopValid high with snoopAddr equal to the reserved address) in any cycle from the reserving load's memory cycle up to and including the conditional store's memory cycle makes that store fail. A snoop to another address has no effect.
- R9: A local store or read-modify-write that writes the reserved address invalidates the reservation. A local write to another address does not.
- R10: An update returns the old word and writes back old+operand (modulo 2^32), the operand (swap), old AND operand, or old OR operand.
- R11: Min and max compare old word and operand as signed 32-bit two's-complement values and write back the smaller or larger one.
- R12: Memory reads return data on memRdata in the cycle after memEn is high with memWe low. An update reads in one cycle and writes in the very next cycle, with no other access in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Unit can accept a request |
| reqOp | input | 4 | Operation code |
| reqAddr | input | ADDR_W | Word address |
| reqData | input | 32 | Store data or update operand |
| rspValid | output | 1 | Response word valid (one cycle) |
| rspData | output | 32 | Old word or status code |
| memEn | output | 1 | Memory access enable |
| memWe | output | 1 | Memory write (1) or read (0) |
| memAddr | output | ADDR_W | Memory word address |
| memWdata | output | 32 | Memory write data |
| memRdata | input | 32 | Memory read data, one cycle after a read |
| snoopValid | input | 1 | Another agent is writing memory |
| snoopAddr | input | ADDR_W | Address written by the other agent |

## Verification
A corrupted reservation shows up at the very next conditional store. That store's status word flips between 0 and 1, and the memory either receives or misses the write, within four cycles of issue. A controller in the wrong state shows up within one cycle, as reqReady staying high after an accept or rspValid landing off its fixed third-cycle slot. The order of an update's two memory cycles is logged at the memory port, so a split or reversed update is caught in the same request.

// File: rtl/amo_pkg.sv
package amo_pkg;
  localparam int DATA_W = 32;

  typedef enum logic [3:0] {
    OP_LOAD  = 4'd0,
    OP_STORE = 4'd1,
    OP_LR    = 4'd2,
    OP_SC    = 4'd3,
    OP_ADD   = 4'd4,
    OP_SWAP  = 4'd5,
    OP_AND   = 4'd6,
    OP_OR    = 4'd7,
    OP_MIN   = 4'd8,
    OP_MAX   = 4'd9
  } amoOpE;

  typedef enum logic [1:0] {
    IDLE         = 2'd0,
    READ         = 2'd1,
    MODIFY_WRITE = 2'd2,
    RESPOND      = 2'd3
  } amoStateE;

  typedef struct packed {
    logic latchReq;
    logic issueRead;
    logic issueStore;
    logic issueSc;
    logic setRes;
    logic captureRd;
    logic writeBack;
  } ctrlStrobeT;

  function automatic logic isRmw(amoOpE op);
    return (op == OP_ADD) || (op == OP_SWAP) || (op == OP_AND) ||
           (op == OP_OR)  || (op == OP_MIN)  || (op == OP_MAX);
  endfunction

  function automatic logic [DATA_W-1:0] amoCombine(amoOpE op,
      logic [DATA_W-1:0] oldV, logic [DATA_W-1:0] opnd);
    logic [DATA_W-1:0] res;
    case (op)
      OP_ADD:  res = oldV + opnd;
      OP_SWAP: res = opnd;
      OP_AND:  res = oldV & opnd;
      OP_OR:   res = oldV | opnd;
      OP_MIN:  res = ($signed(oldV) < $signed(opnd)) ? oldV : opnd;
      OP_MAX:  res = ($signed(oldV) > $signed(opnd)) ? oldV : opnd;
      default: res = oldV;
    endcase
    return res;
  endfunction
endpackage

// File: rtl/amo_ctrl.sv
module amo_ctrl
  import amo_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  amoOpE      opReg,
  output logic       reqReady,
  output logic       rspValid,
  output ctrlStrobeT strobe
);
  amoStateE state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    case (state)
      IDLE:         if (reqValid) stateNext = READ;
      READ:         stateNext = MODIFY_WRITE;
      MODIFY_WRITE: stateNext = RESPOND;
      RESPOND:      stateNext = IDLE;
      default:      stateNext = IDLE;
    endcase
  end

  always_comb begin
    strobe = '0;
    case (state)
      IDLE: strobe.latchReq = reqValid;
      READ: begin
        case (opReg)
          OP_STORE: strobe.issueStore = 1'b1;
          OP_SC:    strobe.issueSc    = 1'b1;
          OP_LR: begin
            strobe.issueRead = 1'b1;
            strobe.setRes    = 1'b1;
          end
          default:  strobe.issueRead = 1'b1;
        endcase
      end
      MODIFY_WRITE: begin
        strobe.captureRd = (opReg != OP_STORE) && (opReg != OP_SC);
        strobe.writeBack = isRmw(opReg);
      end
      default: ;
    endcase
  end

  assign reqReady = (state == IDLE);
  assign rspValid = (state == RESPOND);

  AST_ACCEPT_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady); // R2
  AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> (!rspValid && reqReady)); // R2
  AST_RSP_NOT_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> !reqReady); // R2
endmodule

// File: rtl/amo_datapath.sv
module amo_datapath
  import amo_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobeT        strobe,
  input  logic [3:0]        reqOp,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  input  logic              snoopValid,
  input  logic [ADDR_W-1:0] snoopAddr,
  input  logic [DATA_W-1:0] memRdata,
  output amoOpE             opReg,
  output logic [DATA_W-1:0] rspData,
  output logic              memEn,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata
);
  logic [ADDR_W-1:0] addrReg;
  logic [DATA_W-1:0] dataReg;
  logic [DATA_W-1:0] resultReg;
  logic              resValid;
  logic [ADDR_W-1:0] resAddr;

  logic scPass;
  logic snoopOnRes;
  logic snoopOnCur;
  logic localWrite;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opReg   <= OP_LOAD;
      addrReg <= '0;
      dataReg <= '0;
    end else if (strobe.latchReq) begin
      opReg   <= amoOpE'(reqOp);
      addrReg <= reqAddr;
      dataReg <= reqData;
    end
  end

  assign snoopOnCur = snoopValid && (snoopAddr == addrReg);
  assign snoopOnRes = snoopValid && (snoopAddr == resAddr);
  assign scPass     = resValid && (resAddr == addrReg) && !snoopOnCur;

  assign memWe    = strobe.issueStore || (strobe.issueSc && scPass) ||
                    strobe.writeBack;
  assign memEn    = strobe.issueRead || memWe;
  assign memAddr  = addrReg;
  assign memWdata = strobe.writeBack ? amoCombine(opReg, memRdata, dataReg)
                                     : dataReg;
  assign localWrite = memWe && (addrReg == resAddr);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resValid <= 1'b0;
      resAddr  <= '0;
    end else if (strobe.setRes) begin
      resValid <= !snoopOnCur;
      resAddr  <= addrReg;
    end else if (strobe.issueSc || snoopOnRes || localWrite) begin
      resValid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resultReg <= '0;
    end else if (strobe.issueSc) begin
      resultReg <= {{(DATA_W-1){1'b0}}, !scPass};
    end else if (strobe.issueStore) begin
      resultReg <= '0;
    end else if (strobe.captureRd) begin
      resultReg <= memRdata;
    end
  end

  assign rspData = resultReg;

  AST_RMW_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.writeBack |-> ($past(memEn) && !$past(memWe) &&
                          $past(memAddr) == memAddr)); // R12
  AST_SC_FAIL_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.issueSc && !resValid) |-> !memEn); // R6
  AST_SC_CLEARS_RES: assert property (@(posedge clk) disable iff (!rstN)
    strobe.issueSc |=> !resValid); // R7
  AST_SNOOP_KILLS_RES: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && snoopOnRes && !strobe.setRes) |=> !resValid); // R8
  AST_LOCAL_WRITE_KILLS: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && memWe && memAddr == resAddr) |=> !resValid); // R9
endmodule

// File: rtl/amo_unit.sv
module amo_unit
  import amo_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [3:0]        reqOp,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [31:0]       reqData,
  output logic              rspValid,
  output logic [31:0]       rspData,
  output logic              memEn,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memWdata,
  input  logic [31:0]       memRdata,
  input  logic              snoopValid,
  input  logic [ADDR_W-1:0] snoopAddr
);
  ctrlStrobeT strobe;
  amoOpE      opReg;

  amo_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .opReg    (opReg),
    .reqReady (reqReady),
    .rspValid (rspValid),
    .strobe   (strobe)
  );

  amo_datapath #(.ADDR_W(ADDR_W)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .reqOp      (reqOp),
    .reqAddr    (reqAddr),
    .reqData    (reqData),
    .snoopValid (snoopValid),
    .snoopAddr  (snoopAddr),
    .memRdata   (memRdata),
    .opReg      (opReg),
    .rspData    (rspData),
    .memEn      (memEn),
    .memWe      (memWe),
    .memAddr    (memAddr),
    .memWdata   (memWdata)
  );

  AST_MEM_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> !memEn); // R12
endmodule

// File: tb/amo_unit_tb.sv
module amo_unit_tb_top;
  localparam int AW = 8;
  localparam int NVEC = 17;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic          reqReady;
  logic [3:0]    reqOp = '0;
  logic [AW-1:0] reqAddr = '0;
  logic [31:0]   reqData = '0;
  logic          rspValid;
  logic [31:0]   rspData;
  logic          memEn, memWe;
  logic [AW-1:0] memAddr;
  logic [31:0]   memWdata;
  logic [31:0]   memRdata = '0;
  logic          snoopValid = 1'b0;
  logic [AW-1:0] snoopAddr = '0;

  logic [31:0] mem [256];
  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int accCnt = 0;
  int wrCnt = 0;
  int rdCyc = -1;
  int wrCyc = -1;

  always #4 clk = ~clk;

  amo_unit #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqOp(reqOp), .reqAddr(reqAddr), .reqData(reqData),
    .rspValid(rspValid), .rspData(rspData),
    .memEn(memEn), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .snoopValid(snoopValid), .snoopAddr(snoopAddr)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (memEn) begin
      accCnt = accCnt + 1;
      if (memWe) begin
        mem[memAddr] <= memWdata;
        wrCnt = wrCnt + 1;
        wrCyc = cyc;
      end else begin
        memRdata <= mem[memAddr];
        rdCyc = cyc;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One request with fixed-latency protocol checks (R2) and port log checks (R12)
  task automatic doOp(input logic [3:0] op, input logic [AW-1:0] a,
                      input logic [31:0] d, input bit snoopRd,
                      input logic [AW-1:0] sa, output logic [31:0] rsp);
    @(negedge clk);
    reqValid = 1'b1; reqOp = op; reqAddr = a; reqData = d;
    accCnt = 0; wrCnt = 0; rdCyc = -1; wrCyc = -1;
    chk(reqReady == 1'b1, "R2 ready before accept", {31'b0, reqReady}, 1);
    @(negedge clk);
    reqValid = 1'b0;
    if (snoopRd) begin snoopValid = 1'b1; snoopAddr = sa; end
    chk(!reqReady && !rspValid, "R2 busy cycle 1", {30'b0, reqReady, rspValid}, 0);
    @(negedge clk);
    snoopValid = 1'b0;
    chk(!reqReady && !rspValid, "R2 busy cycle 2", {30'b0, reqReady, rspValid}, 0);
    @(negedge clk);
    chk(rspValid && !reqReady, "R2 response cycle", {30'b0, reqReady, rspValid}, 1);
    rsp = rspData;
    @(negedge clk);
    chk(!rspValid && reqReady, "R2 back to idle", {30'b0, reqReady, rspValid}, 2);
    if (op >= 4'd4 && op <= 4'd9) begin
      chk(accCnt == 2 && wrCnt == 1 && wrCyc == rdCyc + 1, "R12 read then write",
          accCnt, 2);
    end
  endtask

  function automatic string tagOf(input logic [3:0] op, input logic [31:0] exp);
    case (op)
      4'd0, 4'd1: return "R3";
      4'd2:       return "R4";
      4'd3:       return (exp == 0) ? "R5" : "R6";
      4'd8, 4'd9: return "R11";
      default:    return "R10";
    endcase
  endfunction

  // {op, addr, operand, expected response, expected word afterwards}
  localparam logic [107:0] VEC [NVEC] = '{
    {4'd1, 8'd1, 32'h00000010, 32'h00000000, 32'h00000010},
    {4'd0, 8'd1, 32'h00000000, 32'h00000010, 32'h00000010},
    {4'd4, 8'd1, 32'hFFFFFFF5, 32'h00000010, 32'h00000005},
    {4'd5, 8'd1, 32'hA5A5A5A5, 32'h00000005, 32'hA5A5A5A5},
    {4'd6, 8'd1, 32'h0F0F00FF, 32'hA5A5A5A5, 32'h050500A5},
    {4'd7, 8'd1, 32'h30000000, 32'h050500A5, 32'h350500A5},
    {4'd1, 8'd2, 32'hFFFFFFFE, 32'h00000000, 32'hFFFFFFFE},
    {4'd8, 8'd2, 32'h00000003, 32'hFFFFFFFE, 32'hFFFFFFFE},
    {4'd9, 8'd2, 32'h00000003, 32'hFFFFFFFE, 32'h00000003},
    {4'd8, 8'd2, 32'h80000000, 32'h00000003, 32'h80000000},
    {4'd9, 8'd2, 32'h7FFFFFFF, 32'h80000000, 32'h7FFFFFFF},
    {4'd2, 8'd2, 32'h00000000, 32'h7FFFFFFF, 32'h7FFFFFFF},
    {4'd3, 8'd2, 32'h12345678, 32'h00000000, 32'h12345678},
    {4'd3, 8'd2, 32'hDEADBEEF, 32'h00000001, 32'h12345678}, // R7 reuse fails
    {4'd2, 8'd3, 32'h00000000, 32'h00000000, 32'h00000000},
    {4'd3, 8'd4, 32'h00000011, 32'h00000001, 32'h00000000}, // R6 other address
    {4'd3, 8'd3, 32'h00000022, 32'h00000001, 32'h00000000}  // R7 cleared by failure
  };

  task automatic finishRun();
    $display("  test done: total=%0d bad=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    while (cyc < 100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected=<100000", cyc);
    finishRun();
  end

  initial begin
    logic [31:0] r;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(reqReady && !rspValid && !memEn, "R1 reset outputs",
        {29'b0, reqReady, rspValid, memEn}, 4);
    rstN = 1'b1;

    doOp(4'd3, 8'd0, 32'h55, 1'b0, '0, r);
    chk(r == 1 && mem[0] == 0, "R1 first SC fails", r, 1);

    for (int i = 0; i < NVEC; i++) begin
      logic [107:0] v;
      v = VEC[i];
      doOp(v[107:104], v[103:96], v[95:64], 1'b0, '0, r);
      chk(r == v[63:32], tagOf(v[107:104], v[63:32]), r, v[63:32]);
      chk(mem[v[103:96]] == v[31:0], tagOf(v[107:104], v[63:32]),
          mem[v[103:96]], v[31:0]);
      if (v[107:104] == 4'd3 && v[63:32] != 0)
        chk(wrCnt == 0, "R6 no write on failure", wrCnt, 0);
    end

    // R8: snoops between reservation and conditional store
    doOp(4'd2, 8'd5, 0, 1'b0, '0, r);
    @(negedge clk); snoopValid = 1'b1; snoopAddr = 8'd6;
    @(negedge clk); snoopValid = 1'b0;
    doOp(4'd3, 8'd5, 32'hAAAA0001, 1'b0, '0, r);
    chk(r == 0 && mem[5] == 32'hAAAA0001, "R8 other-address snoop ignored", r, 0);

    doOp(4'd2, 8'd5, 0, 1'b0, '0, r);
    @(negedge clk); snoopValid = 1'b1; snoopAddr = 8'd5;
    @(negedge clk); snoopValid = 1'b0;
    doOp(4'd3, 8'd5, 32'hBBBB0002, 1'b0, '0, r);
    chk(r == 1 && mem[5] == 32'hAAAA0001, "R8 matching snoop kills", r, 1);

    doOp(4'd2, 8'd7, 0, 1'b0, '0, r);
    doOp(4'd3, 8'd7, 32'hCCCC0003, 1'b1, 8'd7, r);
    chk(r == 1 && mem[7] == 0, "R8 snoop in SC memory cycle", r, 1);

    doOp(4'd2, 8'd7, 0, 1'b1, 8'd7, r);
    doOp(4'd3, 8'd7, 32'hCCCC0004, 1'b0, '0, r);
    chk(r == 1 && mem[7] == 0, "R8 snoop in LR memory cycle", r, 1);

    // R9: local writes
    doOp(4'd2, 8'd8, 0, 1'b0, '0, r);
    doOp(4'd1, 8'd8, 32'h1, 1'b0, '0, r);
    doOp(4'd3, 8'd8, 32'h99, 1'b0, '0, r);
    chk(r == 1 && mem[8] == 1, "R9 local store kills", r, 1);

    doOp(4'd2, 8'd9, 0, 1'b0, '0, r);
    doOp(4'd4, 8'd9, 32'h1, 1'b0, '0, r);
    doOp(4'd3, 8'd9, 32'h77, 1'b0, '0, r);
    chk(r == 1 && mem[9] == 1, "R9 local update kills", r, 1);

    doOp(4'd2, 8'd9, 0, 1'b0, '0, r);
    doOp(4'd1, 8'd10, 32'h3, 1'b0, '0, r);
    doOp(4'd3, 8'd9, 32'h66, 1'b0, '0, r);
    chk(r == 0 && mem[9] == 32'h66, "R9 other-address store ignored", r, 0);

    // R7: a successful SC also leaves nothing behind
    doOp(4'd3, 8'd9, 32'h67, 1'b0, '0, r);
    chk(r == 1 && mem[9] == 32'h66, "R7 second SC after success", r, 1);

    finishRun();
  end
endmodule